// File: doc/BRIEF.md
# Slow-Clock Source Switch with Crystal Loss Detection

This block picks the slow oscillator that feeds a real-time-clock domain: either the external crystal or the on-chip RC oscillator. Both oscillator waveforms arrive as levels that are sampled by the system clock. The block watches the crystal by counting RC periods between crystal rising edges. When too many RC periods pass with no crystal edge, it raises a loss flag. If automatic failover is enabled, it then moves the domain to the RC oscillator without software help. Every change of source goes through a glitch-free handover. The status output shows the source actually in use, so it lags the request by the length of the handover.

The block also holds a small interrupt register set with three event sources: calibration failure, calibration completion and crystal loss. Each source has its own enable, status, clear-strobe and set-strobe. Writes are single-cycle strobes that share one data bus. Two stop inputs can silence either oscillator while it is the one driving the domain.

Top module: `osc_switchover`

## Requirements
- R1: After reset, `src_cur_o` is 0 (crystal), and `rtc_clk_o`, `xt_fail_o`, `irq_o` and `irq_status_o` are all 0.
- R2: `xt_fail_o` rises one clock after the FAIL_LIMIT-th RC rising edge with no crystal rising edge since the last one. It falls one clock after the next crystal rising edge. A crystal edge and an RC edge in the same cycle count as a crystal edge.
- R3: `src_sel_i` selects 1 = RC oscillator, 0 = crystal. `src_cur_o` uses the same encoding and reports the source in use once the handover completes. In steady state, `rtc_clk_o` repeats the selected oscillator level two clocks late.
- R4: When `failover_en_i` is 1 and `xt_fail_o` is 1, the domain moves to the RC oscillator even with `src_sel_i` = 0. It returns to the crystal after the flag clears. With `failover_en_i` = 0, a crystal loss leaves the domain on the crystal.
- R5: Handover is glitch-free. The block gates the old source only once that source is low, or at once if the old source is a lost crystal. It then waits for the new source to be low before enabling it. `rtc_clk_o` is 0 in any cycle in which `src_cur_o` changes, and a crystal stuck high does not block failover.
- R6: While a stop input is 1 for the source in use, `rtc_clk_o` is held at 0 from the next clock. The stop input of the source not in use has no effect on `rtc_clk_o`.
- R7: Interrupt bit positions are: bit 0 calibration fail, bit 1 calibration complete, bit 2 crystal loss. A clear strobe clears the status bits whose data bits are 1. A set strobe sets them. A pulse on an event input sets its status bit. All of these take effect on the next clock.
- R8: An event and a clear of the same status bit in the same cycle leave the bit set.
- R9: `irq_o` is the OR over the status bits ANDed with the enable register. The enable strobe loads the enable register from `irq_wdata_i`. `irq_o` updates on the same clock as the status it reflects.
- R10: Bit 2 of the status is set on the clock on which `xt_fail_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both oscillators |
| rst | input | 1 | Synchronous active-high reset |
| xt_clk_i | input | 1 | Crystal oscillator level |
| rc_clk_i | input | 1 | RC oscillator level |
| src_sel_i | input | 1 | Requested source, 1 = RC, 0 = crystal |
| failover_en_i | input | 1 | Enables automatic move to RC on crystal loss |
| xt_stop_i | input | 1 | Silences the crystal while it drives the domain |
| rc_stop_i | input | 1 | Silences the RC oscillator while it drives the domain |
| irq_en_we_i | input | 1 | Loads the interrupt enable register |
| irq_clr_we_i | input | 1 | Clears status bits selected by the data |
| irq_set_we_i | input | 1 | Sets status bits selected by the data |
| irq_wdata_i | input | 3 | Write data for the three strobes |
| cal_fail_i | input | 1 | Calibration failure event pulse |
| cal_done_i | input | 1 | Calibration complete event pulse |
| rtc_clk_o | output | 1 | Gated clock for the real-time-clock domain |
| src_cur_o | output | 1 | Source in use, 1 = RC, 0 = crystal |
| xt_fail_o | output | 1 | Crystal enabled but not oscillating |
| irq_o | output | 1 | Interrupt request |
| irq_status_o | output | 3 | Interrupt status bits |

## Verification
Two collisions are provoked on purpose. In the first, a calibration event pulse and a clear strobe for the same bit fall in one cycle, and the bit must read back set. A random phase also mixes event pulses with set, clear and enable strobes on the same cycles and compares status and `irq_o` against a bench model every cycle. In the second, crystal loss arrives while the crystal is stuck high and drives the domain. Loss detection and the handover then overlap, and the bench judges that the switch to RC still completes and that `rtc_clk_o` is low whenever `src_cur_o` changes.

// File: rtl/osc_sw_pkg.sv
package osc_sw_pkg;
  localparam int IRQ_W        = 3;
  localparam int IRQ_CAL_FAIL = 0;
  localparam int IRQ_CAL_DONE = 1;
  localparam int IRQ_OSC_LOSS = 2;

  typedef enum logic [1:0] {
    SW_RUN   = 2'd0,  // source steady, gate open
    SW_DRAIN = 2'd1,  // waiting for the old source to be low
    SW_ARM   = 2'd2   // gate closed, waiting for the new source to be low
  } sw_state_t;
endpackage

// File: rtl/osc_fail_detect.sv
module osc_fail_detect #(
  parameter int FAIL_LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic xt_rise,
  input  logic rc_rise,
  output logic fail_o,
  output logic fail_set_o
);
  localparam int            CW   = $clog2(FAIL_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(FAIL_LIMIT - 1);

  logic [CW-1:0] rc_cnt;

  // Last RC edge of the window, with no crystal edge in the same cycle.
  assign fail_set_o = rc_rise & ~xt_rise & ~fail_o & (rc_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      rc_cnt <= '0;
      fail_o <= 1'b0;
    end else if (xt_rise) begin
      rc_cnt <= '0;
      fail_o <= 1'b0;
    end else if (fail_set_o) begin
      fail_o <= 1'b1;
    end else if (rc_rise && !fail_o) begin
      rc_cnt <= rc_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clk_switch_fsm.sv
module clk_switch_fsm
  import osc_sw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic want_rc,
  input  logic xt_lvl,
  input  logic rc_lvl,
  input  logic xt_lost,
  output logic cur_rc,
  output logic gate_o
);
  sw_state_t state;
  logic      tgt_rc;
  logic      old_lvl;
  logic      new_lvl;

  assign old_lvl = cur_rc ? rc_lvl : xt_lvl;
  assign new_lvl = tgt_rc ? rc_lvl : xt_lvl;
  assign gate_o  = (state != SW_ARM);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SW_RUN;
      cur_rc <= 1'b0;
      tgt_rc <= 1'b0;
    end else begin
      case (state)
        SW_RUN: if (want_rc != cur_rc) begin
          tgt_rc <= want_rc;
          state  <= SW_DRAIN;
        end
        SW_DRAIN: if (!old_lvl || (!cur_rc && xt_lost)) begin
          state <= SW_ARM;
        end
        SW_ARM: if (!new_lvl) begin
          cur_rc <= tgt_rc;
          state  <= SW_RUN;
        end
        default: state <= SW_RUN;
      endcase
    end
  end
endmodule

// File: rtl/osc_irq_regs.sv
module osc_irq_regs
  import osc_sw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_W-1:0] evt_i,
  input  logic             en_we,
  input  logic             clr_we,
  input  logic             set_we,
  input  logic [IRQ_W-1:0] wdata,
  output logic [IRQ_W-1:0] status_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] en_q;
  logic [IRQ_W-1:0] en_n;
  logic [IRQ_W-1:0] st_n;
  logic [IRQ_W-1:0] clr_m;
  logic [IRQ_W-1:0] set_m;

  assign clr_m = clr_we ? wdata : '0;
  assign set_m = set_we ? wdata : '0;
  // Events and set strobes win over a clear in the same cycle.
  assign st_n  = (status_o & ~clr_m) | evt_i | set_m;
  assign en_n  = en_we ? wdata : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      en_q     <= en_n;
      status_o <= st_n;
      irq_o    <= |(st_n & en_n);
    end
  end
endmodule

// File: rtl/osc_switchover.sv
module osc_switchover
  import osc_sw_pkg::*;
#(
  parameter int FAIL_LIMIT = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xt_clk_i,
  input  logic             rc_clk_i,
  input  logic             src_sel_i,
  input  logic             failover_en_i,
  input  logic             xt_stop_i,
  input  logic             rc_stop_i,
  input  logic             irq_en_we_i,
  input  logic             irq_clr_we_i,
  input  logic             irq_set_we_i,
  input  logic [IRQ_W-1:0] irq_wdata_i,
  input  logic             cal_fail_i,
  input  logic             cal_done_i,
  output logic             rtc_clk_o,
  output logic             src_cur_o,
  output logic             xt_fail_o,
  output logic             irq_o,
  output logic [IRQ_W-1:0] irq_status_o
);
  logic             xt_q, rc_q;
  logic             xt_rise, rc_rise;
  logic             xt_eff, rc_eff;
  logic             fail_set;
  logic             want_rc;
  logic             gate;
  logic [IRQ_W-1:0] evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      xt_q <= 1'b0;
      rc_q <= 1'b0;
    end else begin
      xt_q <= xt_clk_i;
      rc_q <= rc_clk_i;
    end
  end

  assign xt_rise = xt_clk_i & ~xt_q;
  assign rc_rise = rc_clk_i & ~rc_q;
  assign xt_eff  = xt_q & ~xt_stop_i;
  assign rc_eff  = rc_q & ~rc_stop_i;
  assign want_rc = src_sel_i | (failover_en_i & xt_fail_o);

  osc_fail_detect #(.FAIL_LIMIT(FAIL_LIMIT)) u_det (
    .clk        (clk),
    .rst        (rst),
    .xt_rise    (xt_rise),
    .rc_rise    (rc_rise),
    .fail_o     (xt_fail_o),
    .fail_set_o (fail_set)
  );

  clk_switch_fsm u_sw (
    .clk     (clk),
    .rst     (rst),
    .want_rc (want_rc),
    .xt_lvl  (xt_eff),
    .rc_lvl  (rc_eff),
    .xt_lost (xt_fail_o),
    .cur_rc  (src_cur_o),
    .gate_o  (gate)
  );

  always_ff @(posedge clk) begin
    if (rst) rtc_clk_o <= 1'b0;
    else     rtc_clk_o <= gate & (src_cur_o ? rc_eff : xt_eff);
  end

  always_comb begin
    evt               = '0;
    evt[IRQ_CAL_FAIL] = cal_fail_i;
    evt[IRQ_CAL_DONE] = cal_done_i;
    evt[IRQ_OSC_LOSS] = fail_set;
  end

  osc_irq_regs u_irq (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt),
    .en_we    (irq_en_we_i),
    .clr_we   (irq_clr_we_i),
    .set_we   (irq_set_we_i),
    .wdata    (irq_wdata_i),
    .status_o (irq_status_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/osc_switchover_chk.sv
module osc_switchover_chk (
  input logic       clk,
  input logic       rst,
  input logic       rc_clk_i,
  input logic       xt_stop_i,
  input logic       rc_stop_i,
  input logic       irq_clr_we_i,
  input logic       irq_set_we_i,
  input logic [2:0] irq_wdata_i,
  input logic       cal_fail_i,
  input logic       cal_done_i,
  input logic       rtc_clk_o,
  input logic       src_cur_o,
  input logic       xt_fail_o,
  input logic       irq_o,
  input logic [2:0] irq_status_o
);
  // R2
  fail_on_rc_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(xt_fail_o) |-> ($past(rc_clk_i) && !$past(rc_clk_i, 2)));

  // R5
  quiet_handover_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(src_cur_o) |-> !rtc_clk_o);

  // R6
  xt_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (xt_stop_i && !src_cur_o) |=> !rtc_clk_o);

  // R6
  rc_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (rc_stop_i && src_cur_o) |=> !rtc_clk_o);

  // R7
  clear_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr_we_i && irq_wdata_i[1] && !cal_done_i && !irq_set_we_i) |=> !irq_status_o[1]);

  // R8
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cal_fail_i |=> irq_status_o[0]);

  // R9
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (irq_status_o != 3'b000));

  // R10
  loss_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(xt_fail_o) |-> irq_status_o[2]);
endmodule

bind osc_switchover osc_switchover_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .rc_clk_i     (rc_clk_i),
  .xt_stop_i    (xt_stop_i),
  .rc_stop_i    (rc_stop_i),
  .irq_clr_we_i (irq_clr_we_i),
  .irq_set_we_i (irq_set_we_i),
  .irq_wdata_i  (irq_wdata_i),
  .cal_fail_i   (cal_fail_i),
  .cal_done_i   (cal_done_i),
  .rtc_clk_o    (rtc_clk_o),
  .src_cur_o    (src_cur_o),
  .xt_fail_o    (xt_fail_o),
  .irq_o        (irq_o),
  .irq_status_o (irq_status_o)
);

// File: tb/osc_switchover_bench.sv
module osc_switchover_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 64;
  localparam int XT_HALF    = 3;
  localparam int RC_HALF    = 5;
  localparam int WD_MAX     = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xt_clk_i = 1'b0, rc_clk_i = 1'b0;
  logic       src_sel_i = 1'b0, failover_en_i = 1'b0;
  logic       xt_stop_i = 1'b0, rc_stop_i = 1'b0;
  logic       irq_en_we_i = 1'b0, irq_clr_we_i = 1'b0, irq_set_we_i = 1'b0;
  logic [2:0] irq_wdata_i = 3'b000;
  logic       cal_fail_i = 1'b0, cal_done_i = 1'b0;
  logic       rtc_clk_o, src_cur_o, xt_fail_o, irq_o;
  logic [2:0] irq_status_o;

  osc_switchover #(.FAIL_LIMIT(LIMIT)) u_osc_switchover (
    .clk(clk), .rst(rst), .xt_clk_i(xt_clk_i), .rc_clk_i(rc_clk_i),
    .src_sel_i(src_sel_i), .failover_en_i(failover_en_i),
    .xt_stop_i(xt_stop_i), .rc_stop_i(rc_stop_i),
    .irq_en_we_i(irq_en_we_i), .irq_clr_we_i(irq_clr_we_i),
    .irq_set_we_i(irq_set_we_i), .irq_wdata_i(irq_wdata_i),
    .cal_fail_i(cal_fail_i), .cal_done_i(cal_done_i),
    .rtc_clk_o(rtc_clk_o), .src_cur_o(src_cur_o), .xt_fail_o(xt_fail_o),
    .irq_o(irq_o), .irq_status_o(irq_status_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int   n_chk = 0, n_fail = 0, wd = 0;
  int   fail_mis = 0, glitch_mis = 0;
  int   xph = 0, rph = 0, fcnt = 0;
  bit   osc_on = 0, xt_run = 1, mon_on = 0, fexp = 0;
  logic xt_hold = 1'b0;
  logic xh0 = 1'b0, xh1 = 1'b0, rh0 = 1'b0, rh1 = 1'b0;
  logic exp_x = 1'b0, exp_r = 1'b0, cur_prev = 1'b0;
  logic [2:0] st_m = 3'b000, en_m = 3'b000;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // One system clock: sample at the falling edge, then drive new oscillator levels.
  task automatic tick();
    logic xn, rn;
    @(negedge clk);
    wd++;
    if (wd > WD_MAX) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, WD_MAX);
      finish_run();
    end
    if (mon_on) begin
      if (xt_fail_o !== fexp) fail_mis++;
      if (src_cur_o !== cur_prev && rtc_clk_o !== 1'b0) glitch_mis++;
    end
    cur_prev = src_cur_o;
    exp_x = xh1; exp_r = rh1;
    xh1 = xh0; rh1 = rh0;
    if (!osc_on) begin
      xn = 1'b0; rn = 1'b0;
    end else begin
      if (xt_run) begin xph = (xph + 1) % (2*XT_HALF); xn = (xph < XT_HALF); end
      else xn = xt_hold;
      rph = (rph + 1) % (2*RC_HALF);
      rn  = (rph < RC_HALF);
      if (xn && !xh0) begin fcnt = 0; fexp = 0; end
      else if (rn && !rh0 && !fexp) begin
        fcnt++;
        if (fcnt >= LIMIT) fexp = 1;
      end
    end
    xh0 = xn; rh0 = rn;
    xt_clk_i = xn; rc_clk_i = rn;
  endtask

  task automatic steady(input int n, input bit on_rc, input bit stopped, input string tag);
    int mis = 0;
    for (int i = 0; i < n; i++) begin
      logic e;
      tick();
      e = stopped ? 1'b0 : (on_rc ? exp_r : exp_x);
      if (rtc_clk_o !== e) mis++;
    end
    chk(mis == 0, tag, mis, 0);
  endtask

  task automatic wait_src(input logic want, input string tag);
    int k = 0;
    while (src_cur_o !== want && k < 80) begin tick(); k++; end
    chk(src_cur_o === want, tag, src_cur_o, want);
  endtask

  function automatic logic [2:0] st_next(input logic [2:0] st, input logic [2:0] ev,
                                          input logic [2:0] setm, input logic [2:0] clrm);
    return (st & ~clrm) | ev | setm;
  endfunction

  task automatic irq_cyc(input bit en_we, input bit clr_we, input bit set_we,
                         input logic [2:0] wdat, input bit cf, input bit cd);
    irq_en_we_i = en_we; irq_clr_we_i = clr_we; irq_set_we_i = set_we;
    irq_wdata_i = wdat; cal_fail_i = cf; cal_done_i = cd;
    st_m = st_next(st_m, {1'b0, cd, cf}, set_we ? wdat : 3'b0, clr_we ? wdat : 3'b0);
    if (en_we) en_m = wdat;
    tick();
    irq_en_we_i = 0; irq_clr_we_i = 0; irq_set_we_i = 0;
    irq_wdata_i = 3'b000; cal_fail_i = 0; cal_done_i = 0;
  endtask

  initial begin
    int rmis = 0;
    void'($urandom(32'd2024));
    repeat (5) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(src_cur_o === 1'b0 && rtc_clk_o === 1'b0 && xt_fail_o === 1'b0, "R1 outputs",
        {src_cur_o, rtc_clk_o, xt_fail_o}, 0);
    chk(irq_o === 1'b0 && irq_status_o === 3'b000, "R1 irq", {irq_o, irq_status_o}, 0);
    osc_on = 1; mon_on = 1; cur_prev = src_cur_o;
    repeat (4) tick();

    steady(40, 0, 0, "R3 crystal drives output");
    chk(src_cur_o === 1'b0, "R3 status crystal", src_cur_o, 0);
    src_sel_i = 1'b1;
    wait_src(1'b1, "R3 switch to RC");
    steady(40, 1, 0, "R3 RC drives output");

    xt_stop_i = 1'b1; tick();
    steady(30, 1, 0, "R6 inactive stop ignored");
    rc_stop_i = 1'b1; tick();
    steady(30, 1, 1, "R6 active stop silences");
    rc_stop_i = 1'b0; xt_stop_i = 1'b0;
    src_sel_i = 1'b0;
    wait_src(1'b0, "R3 switch back to crystal");
    steady(30, 0, 0, "R3 crystal again");

    // Crystal stops low, failover off
    xt_hold = 1'b0; xt_run = 0;
    repeat (LIMIT*2*RC_HALF + 40) tick();
    chk(xt_fail_o === 1'b1, "R2 loss flagged", xt_fail_o, 1);
    chk(src_cur_o === 1'b0, "R4 no failover when disabled", src_cur_o, 0);
    chk(irq_status_o[2] === 1'b1, "R10 loss status bit", irq_status_o[2], 1);
    failover_en_i = 1'b1;
    wait_src(1'b1, "R4 failover to RC");
    steady(30, 1, 0, "R4 RC after failover");
    xt_run = 1;
    repeat (12) tick();
    chk(xt_fail_o === 1'b0, "R2 loss cleared by crystal edge", xt_fail_o, 0);
    wait_src(1'b0, "R4 return to crystal");

    // Crystal stuck high while driving the domain
    repeat (10) tick();
    xt_hold = 1'b1; xt_run = 0;
    repeat (LIMIT*2*RC_HALF + 40) tick();
    chk(src_cur_o === 1'b1, "R5 stuck-high crystal does not block handover", src_cur_o, 1);
    xt_run = 1;
    wait_src(1'b0, "R4 return after stuck-high");
    repeat (10) tick();
    chk(fail_mis == 0, "R2 flag timing matches model", fail_mis, 0);
    chk(glitch_mis == 0, "R5 output low at every source change", glitch_mis, 0);

    // Interrupt registers
    failover_en_i = 1'b0;
    irq_cyc(1, 1, 0, 3'b111, 0, 0);
    irq_cyc(1, 0, 0, 3'b000, 0, 0);
    chk(irq_status_o === 3'b000, "R7 clear all", irq_status_o, 0);
    irq_cyc(0, 0, 1, 3'b010, 0, 0);
    chk(irq_status_o === 3'b010 && irq_o === 1'b0, "R9 masked status",
        {irq_o, irq_status_o}, 2);
    irq_cyc(1, 0, 0, 3'b010, 0, 0);
    chk(irq_o === 1'b1, "R9 enabled status raises irq", irq_o, 1);
    irq_cyc(0, 1, 0, 3'b010, 0, 0);
    chk(irq_status_o === 3'b000 && irq_o === 1'b0, "R7 clear bit1",
        {irq_o, irq_status_o}, 0);
    irq_cyc(0, 1, 0, 3'b001, 1, 0);
    chk(irq_status_o === 3'b001, "R8 event beats clear", irq_status_o, 1);
    irq_cyc(0, 0, 0, 3'b000, 0, 1);
    chk(irq_status_o === 3'b011, "R7 calibration done event", irq_status_o, 3);
    for (int i = 0; i < 300; i++) begin
      logic [2:0] w;
      w = 3'($urandom);
      irq_cyc(($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 5) == 0, w,
              ($urandom % 6) == 0, ($urandom % 6) == 0);
      if (irq_status_o !== st_m || irq_o !== |(st_m & en_m)) rmis++;
    end
    chk(rmis == 0, "R7 R8 R9 random strobes and events", rmis, 0);
    finish_run();
  end
endmodule